// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one 16-bit down-counting timer channel with its own gate input and output line. A separate register front end hands it a mode, a decimal-counting flag, an initial count and a one-cycle strobe that marks a fresh count write. The channel then drives its output line according to the chosen mode. It also presents its live count and output level so that the front end can latch them for reads.

Two modes are provided. The retriggerable one-shot drives a low pulse that is N clocks long after each rising gate edge. A new edge during the pulse restarts it. The rate generator divides the clock by N. Each period carries a single low clock while the count sits at 1, and the count then reloads on its own. Counting runs either in plain binary or in four-digit BCD. An initial count of zero stands for the largest count the chosen radix can hold.

Top module: `pit_channel`

## Requirements
- R1: After reset, `out` is 1 and `count` is 0. Until the first count write, `count` does not change and `out` stays 1, whatever `gate` does.
- R2: A clock edge with `cfg_wr` = 1 captures `cfg_mode`, `cfg_bcd` and `cfg_count` and sets `out` to 1 at that edge. The next edge loads `count` with the captured value, and counting then goes on from it. A write made while the channel is running takes effect the same way.
- R3: With `cfg_bcd` = 0 the count decrements in binary. 0 wraps to 0xFFFF, so an initial count of 0 acts as 65536.
- R4: With `cfg_bcd` = 1 the count decrements as four BCD digits with a borrow between digits (0x0100 becomes 0x0099). 0x0000 wraps to 0x9999, so an initial count of 0 acts as 10000.
- R5: In one-shot mode (`cfg_mode` = 0), `gate` passes through two synchronizing flops. A rising edge, first set up before clock edge G, reloads the count and drives `out` low at edge G+2. `out` stays low for exactly N clocks and returns high at edge G+2+N.
- R6: In one-shot mode, a rising gate edge that arrives during the pulse reloads N. `out` stays low, and the pulse ends N clocks after the later trigger takes effect.
- R7: In one-shot mode, between pulses and after a write, `out` is 1 and `count` holds its value.
- R8: In rate mode (`cfg_mode` = 1) with `gate` held high and N ≥ 2, `out` first falls at edge W+N after the write edge W. It is low for exactly one clock, while the count is 1. After that the count reloads N and the fall repeats every N clocks.
- R9: In rate mode, a synchronized low `gate` freezes `count` and holds `out` at 1. A rising gate edge, first set up before edge G, reloads N at edge G+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate | input | 1 | Gate/trigger input, asynchronous to clk |
| cfg_wr | input | 1 | One-cycle strobe: a new count and mode are present |
| cfg_mode | input | 1 | 0 = retriggerable one-shot, 1 = rate generator |
| cfg_bcd | input | 1 | 0 = binary counting, 1 = four-digit BCD |
| cfg_count | input | 16 | Initial count N (0 means the maximum) |
| out | output | 1 | Channel output line |
| count | output | 16 | Live count value for latching by the front end |

## Verification
Several behaviours are checked by the assertions on every cycle. In rate mode a low output never lasts longer than one clock, and a low gate holds both the output level and the count. A running one-shot always keeps its output low. An idle one-shot, or a channel that has not yet been written, never moves its count. Every load puts the captured initial count into the counter. Other behaviours can only be shown by the bench's scenarios. These are the exact edge on which the output falls after a write or a gate edge, the full pulse widths and periods (including the 65536 and 10000 maximums), the borrow sequence between BCD digits, and how far a retrigger stretches the pulse.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic {
    MODE_ONESHOT = 1'b0,
    MODE_RATE    = 1'b1
  } pit_mode_e;

  localparam int DIGIT_W = 4;
endpackage

// File: rtl/pit_gate_sync.sv
module pit_gate_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_async,
  output logic gate_lvl,
  output logic gate_rise
);
  logic [STAGES-1:0] sync_q;
  logic              lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      lvl_d  <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], gate_async};
      lvl_d  <= sync_q[STAGES-1];
    end
  end

  assign gate_lvl  = sync_q[STAGES-1];
  assign gate_rise = sync_q[STAGES-1] & ~lvl_d;
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec_en,
  input  logic             bcd,
  output logic [CNT_W-1:0] cnt,
  output logic             cnt_is1,
  output logic             cnt_is2
);
  localparam int DIGITS = CNT_W / DIGIT_W;

  function automatic logic [CNT_W-1:0] bin_dec(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] bcd_dec(input logic [CNT_W-1:0] v);
    logic [CNT_W-1:0]   r;
    logic               borrow;
    logic [DIGIT_W-1:0] d;
    r      = v;
    borrow = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      d = v[i*DIGIT_W +: DIGIT_W];
      if (borrow) begin
        if (d == '0) begin
          r[i*DIGIT_W +: DIGIT_W] = DIGIT_W'(9);
        end else begin
          r[i*DIGIT_W +: DIGIT_W] = d - DIGIT_W'(1);
          borrow = 1'b0;
        end
      end
    end
    return r;
  endfunction

  logic [CNT_W-1:0] cnt_next;

  always_comb begin
    if (load)        cnt_next = load_val;
    else if (dec_en) cnt_next = bcd ? bcd_dec(cnt) : bin_dec(cnt);
    else             cnt_next = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_next;
  end

  assign cnt_is1 = (cnt == CNT_W'(1));
  assign cnt_is2 = (cnt == CNT_W'(2));
endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  pit_mode_e        wr_mode,
  input  logic             wr_bcd,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             gate_lvl,
  input  logic             gate_rise,
  input  logic             cnt_is1,
  input  logic             cnt_is2,
  output logic             load,
  output logic             dec_en,
  output logic             out_q,
  output logic             bcd_q,
  output logic             prog_q,
  output logic             pend_q,
  output logic             run_q,
  output pit_mode_e        mode_q,
  output logic [CNT_W-1:0] init_q
);
  logic active;

  always_comb begin
    active = prog_q & ~wr;
    if (mode_q == MODE_ONESHOT) begin
      load   = active & (pend_q | gate_rise);
      dec_en = active & run_q & ~load;
    end else begin
      load   = active & (pend_q | gate_rise | (gate_lvl & cnt_is1));
      dec_en = active & gate_lvl & ~load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ONESHOT;
      bcd_q  <= 1'b0;
      init_q <= '0;
      pend_q <= 1'b0;
      run_q  <= 1'b0;
      out_q  <= 1'b1;
      prog_q <= 1'b0;
    end else if (wr) begin
      mode_q <= wr_mode;
      bcd_q  <= wr_bcd;
      init_q <= wr_val;
      pend_q <= 1'b1;
      run_q  <= 1'b0;
      out_q  <= 1'b1;
      prog_q <= 1'b1;
    end else if (prog_q) begin
      pend_q <= 1'b0;
      if (mode_q == MODE_ONESHOT) begin
        if (gate_rise) begin
          run_q <= 1'b1;
          out_q <= 1'b0;
        end else if (run_q && cnt_is1) begin
          run_q <= 1'b0;
          out_q <= 1'b1;
        end
      end else begin
        run_q <= 1'b0;
        if (!gate_lvl || load) out_q <= 1'b1;
        else                   out_q <= ~cnt_is2;
      end
    end
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate,
  input  logic             cfg_wr,
  input  logic             cfg_mode,
  input  logic             cfg_bcd,
  input  logic [CNT_W-1:0] cfg_count,
  output logic             out,
  output logic [CNT_W-1:0] count
);
  logic             gate_lvl, gate_rise;
  logic             load, dec_en, cnt_is1, cnt_is2;
  logic             bcd_q, prog_q, pend_q, run_q, out_q;
  pit_mode_e        mode_q;
  logic [CNT_W-1:0] init_q;

  pit_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .gate_async(gate),
    .gate_lvl(gate_lvl), .gate_rise(gate_rise)
  );

  pit_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
    .wr_mode(pit_mode_e'(cfg_mode)), .wr_bcd(cfg_bcd), .wr_val(cfg_count),
    .gate_lvl(gate_lvl), .gate_rise(gate_rise),
    .cnt_is1(cnt_is1), .cnt_is2(cnt_is2),
    .load(load), .dec_en(dec_en), .out_q(out_q), .bcd_q(bcd_q),
    .prog_q(prog_q), .pend_q(pend_q), .run_q(run_q),
    .mode_q(mode_q), .init_q(init_q)
  );

  pit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(init_q),
    .dec_en(dec_en), .bcd(bcd_q), .cnt(count),
    .cnt_is1(cnt_is1), .cnt_is2(cnt_is2)
  );

  assign out = out_q;
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr,
  input logic             out,
  input logic [CNT_W-1:0] count,
  input pit_mode_e        mode_q,
  input logic             prog_q,
  input logic             run_q,
  input logic             pend_q,
  input logic             gate_lvl,
  input logic             gate_rise,
  input logic             load,
  input logic [CNT_W-1:0] init_q
);
  logic is_rate, is_os;
  assign is_rate = prog_q && (mode_q == MODE_RATE);
  assign is_os   = prog_q && (mode_q == MODE_ONESHOT);

  AST_IDLE_UNPROG: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_q && !cfg_wr |=> $stable(count) && out);  // R1
  AST_WR_OUT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> out);  // R2
  AST_LOAD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(init_q));  // R2
  AST_OS_RUN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    is_os && run_q |-> !out);  // R5
  AST_OS_RETRIG: assert property (@(posedge clk) disable iff (!rst_n)
    is_os && gate_rise && !cfg_wr |=> !out && count == $past(init_q));  // R6
  AST_OS_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    is_os && !run_q && !pend_q && !gate_rise && !cfg_wr |=> $stable(count) && out);  // R7
  AST_RATE_LOW_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    is_rate && !out |=> out);  // R8
  AST_RATE_GATE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    is_rate && !gate_lvl |=> out);  // R9
  AST_RATE_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    is_rate && !gate_lvl && !pend_q && !cfg_wr |=> $stable(count));  // R9
endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .out(out), .count(count),
  .mode_q(mode_q), .prog_q(prog_q), .run_q(run_q), .pend_q(pend_q),
  .gate_lvl(gate_lvl), .gate_rise(gate_rise), .load(load), .init_q(init_q)
);

// File: tb/pit_channel_tb.sv
module pit_channel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        gate = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_mode = 1'b0;
  logic        cfg_bcd = 1'b0;
  logic [15:0] cfg_count = '0;
  logic        out;
  logic [15:0] count;

  int checks = 0, errors = 0;
  int cyc = 0, fall_cyc = 0, rise_cyc = 0, fall_n = 0, rise_n = 0;
  int w_edge = 0;
  logic prev_out = 1'b1;

  always #4 clk = ~clk;

  pit_channel u_dut (
    .clk(clk), .rst_n(rst_n), .gate(gate), .cfg_wr(cfg_wr),
    .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd), .cfg_count(cfg_count),
    .out(out), .count(count)
  );

  always @(posedge clk) begin
    cyc++;
    #2;
    if (prev_out && !out) begin fall_cyc = cyc; fall_n++; end
    if (!prev_out && out) begin rise_cyc = cyc; rise_n++; end
    prev_out = out;
  end

  function automatic int from_bcd(input logic [15:0] v);
    return v[15:12]*1000 + v[11:8]*100 + v[7:4]*10 + v[3:0];
  endfunction

  function automatic logic [15:0] to_bcd(input int n);
    return {4'(n/1000), 4'((n/100)%10), 4'((n/10)%10), 4'(n%10)};
  endfunction

  function automatic logic [15:0] bcd_minus1(input logic [15:0] v);
    return to_bcd((from_bcd(v) + 9999) % 10000);
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic prog(input bit m, input bit b, input logic [15:0] v);
    @(negedge clk);
    cfg_mode = m; cfg_bcd = b; cfg_count = v; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
    w_edge = cyc;
  endtask

  task automatic wait_fall(input int n0);
    while (fall_n == n0) @(negedge clk);
  endtask

  task automatic wait_rise(input int n0);
    while (rise_n == n0) @(negedge clk);
  endtask

  task automatic oneshot_run(input bit b, input int n);
    logic [15:0] v;
    int fn, rn, g;
    v = b ? to_bcd(n % 10000) : 16'(n);
    gate = 1'b0;
    repeat (4) @(negedge clk);
    prog(1'b0, b, v);
    repeat (3) @(negedge clk);
    chk("R7 idle count", int'(count), int'(v));
    chk("R7 idle out", int'(out), 1);
    fn = fall_n; rn = rise_n;
    gate = 1'b1; g = cyc + 1;
    wait_fall(fn);
    chk("R5 fall edge", fall_cyc, g + 2);
    wait_rise(rn);
    chk("R5 pulse width", rise_cyc - fall_cyc, n);
    gate = 1'b0;
  endtask

  task automatic rate_run(input bit b, input int n);
    logic [15:0] v;
    int fn, rn, f1;
    v = b ? to_bcd(n) : 16'(n);
    gate = 1'b1;
    repeat (4) @(negedge clk);
    prog(1'b1, b, v);
    fn = fall_n;
    wait_fall(fn);
    chk("R8 first fall", fall_cyc - w_edge, n);
    f1 = fall_cyc; rn = rise_n; fn = fall_n;
    wait_rise(rn);
    chk("R8 low width", rise_cyc - f1, 1);
    wait_fall(fn);
    chk("R8 period", fall_cyc - f1, n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int fn, rn, g, g2, n, c1;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset out", int'(out), 1);
    chk("R1 reset count", int'(count), 0);
    gate = 1'b1; repeat (4) @(negedge clk);
    gate = 1'b0; repeat (4) @(negedge clk);
    chk("R1 unprogrammed count", int'(count), 0);
    chk("R1 unprogrammed out", int'(out), 1);

    // R2: rewrite while running
    gate = 1'b1; repeat (4) @(negedge clk);
    prog(1'b1, 1'b0, 16'd50);
    repeat (10) @(negedge clk);
    prog(1'b1, 1'b0, 16'd7);
    chk("R2 out after write", int'(out), 1);
    @(negedge clk);
    chk("R2 load next edge", int'(count), 7);
    @(negedge clk);
    chk("R2 continues", int'(count), 6);

    // R3: binary wrap of zero count
    prog(1'b1, 1'b0, 16'h0000);
    repeat (2) @(negedge clk);
    chk("R3 binary wrap", int'(count), 16'hFFFF);

    // R4: BCD borrow and wrap
    prog(1'b1, 1'b1, 16'h0100);
    repeat (2) @(negedge clk);
    chk("R4 bcd borrow", int'(count), int'(bcd_minus1(16'h0100)));
    prog(1'b1, 1'b1, 16'h0000);
    repeat (2) @(negedge clk);
    chk("R4 bcd wrap", int'(count), int'(bcd_minus1(16'h0000)));

    // directed one-shot and rate cases
    oneshot_run(1'b0, 1);
    oneshot_run(1'b0, 5);
    oneshot_run(1'b1, 12);
    rate_run(1'b0, 2);
    rate_run(1'b1, 15);

    // R6: retrigger during the pulse
    gate = 1'b0; repeat (4) @(negedge clk);
    prog(1'b0, 1'b0, 16'd20);
    repeat (3) @(negedge clk);
    fn = fall_n; rn = rise_n;
    gate = 1'b1; g = cyc + 1;
    repeat (8) @(negedge clk);
    gate = 1'b0;
    repeat (2) @(negedge clk);
    gate = 1'b1; g2 = cyc + 1;
    wait_rise(rn);
    chk("R6 first fall", fall_cyc, g + 2);
    chk("R6 single pulse", fall_n - fn, 1);
    chk("R6 stretched end", rise_cyc, g2 + 2 + 20);
    gate = 1'b0;

    // R9: gate low suspends rate mode
    gate = 1'b1; repeat (4) @(negedge clk);
    prog(1'b1, 1'b0, 16'd10);
    repeat (4) @(negedge clk);
    gate = 1'b0;
    repeat (4) @(negedge clk);
    c1 = int'(count);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R9 count frozen", int'(count), c1);
      chk("R9 out high", int'(out), 1);
    end
    fn = fall_n;
    gate = 1'b1; g = cyc + 1;
    repeat (3) @(negedge clk);
    chk("R9 reload on rise", int'(count), 10);
    wait_fall(fn);
    chk("R9 fall after reload", fall_cyc, g + 1 + 10);

    // random mix
    for (int k = 0; k < 12; k++) begin
      n = 2 + int'($urandom % 59);
      if ($urandom % 2) rate_run(1'($urandom % 2), n);
      else              oneshot_run(1'($urandom % 2), n);
    end

    // maximum counts (R3, R4)
    oneshot_run(1'b1, 10000);
    chk("R4 bcd max width", rise_cyc - fall_cyc, 10000);
    oneshot_run(1'b0, 65536);
    chk("R3 binary max width", rise_cyc - fall_cyc, 65536);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule